// File: doc/BRIEF.md
# Dual Gated One-Shot Pulse Generator

This block produces one clean pulse of a programmable length each time a qualified trigger event occurs. Each channel uses a loadable down-counter clocked by the system clock as its timing element, so a pulse lasts a whole number of clock cycles set by a 16-bit width value. Each channel has three control inputs: an active-low trigger, an active-high trigger and an active-low clear. All three are sampled on the system clock. Each channel drives a true output and its complement.

A pulse can start in three ways. The active-high trigger can rise while the active-low trigger is held low. The active-low trigger can fall while the active-high trigger is held high. The clear can be released while the active-low trigger is low and the active-high trigger is high. A low clear holds the output low and cuts short any pulse in progress. A pulse that has started runs to its end; further qualifying events are ignored until it ends. The top level contains `NCH` channels (two by default) that share only the clock and reset.

Top module: `dual_oneshot`

## Requirements
- R1: A rising edge on `trig_b[i]` while `trig_a_n[i]` is low and `clr_n[i]` is high starts a pulse on `q[i]`.
- R2: A falling edge on `trig_a_n[i]` while `trig_b[i]` is high and `clr_n[i]` is high starts a pulse on `q[i]`.
- R3: A rising edge on `clr_n[i]` while `trig_a_n[i]` is low and `trig_b[i]` is high starts a pulse on `q[i]`.
- R4: Once `clr_n[i]` has been low at three consecutive rising clock edges, `q[i]` is low and `q_n[i]` is high. This holds even during a pulse, which then ends early, and whatever the triggers do.
- R5: Without a qualifying edge, `q[i]` stays low. For example, the active-high trigger rising while the active-low trigger is high, or the active-low trigger falling while the active-high trigger is low, does nothing.
- R6: A pulse keeps `q[i]` high for exactly `width[16*i +: 16]` clock cycles, sampled when the pulse starts. A width of 0 gives a one-cycle pulse.
- R7: A qualifying edge that arrives while `q[i]` is high is ignored. The pulse keeps its original length, and no second pulse follows.
- R8: While `rst` is high, `q` is all zeros and `q_n` all ones. The input samplers reset to the idle levels (active-low trigger high, active-high trigger low, clear high). `q_n` always equals `~q`.
- R9: Channels are independent: the inputs of one channel never change the output of another.
- R10: An input change made between clock edges reaches `q` at the third rising edge after it: two synchronizer stages, then the registered output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_a_n | input | NCH | Active-low trigger, one bit per channel |
| trig_b | input | NCH | Active-high trigger, one bit per channel |
| clr_n | input | NCH | Active-low clear, one bit per channel |
| width | input | NCH*CW | Pulse width in cycles, CW bits per channel, channel i at [CW*i +: CW] |
| q | output | NCH | Pulse output, one bit per channel |
| q_n | output | NCH | Complement of `q` |

## Verification
Two functions can fall in the same cycle. A qualifying trigger edge can arrive while a pulse is still counting down, and a clear can fall in the middle of a running pulse while the triggers keep toggling. The bench provokes both: it pulses the active-high trigger low and then high again partway through a pulse, and it drops the clear two cycles into a pulse and then toggles a trigger. A behavioural reference model, updated every clock, judges each case. Directed checks also measure the total pulse length, confirm that no second pulse follows, and confirm that the output stays low until the clear is released.

// File: rtl/os_pkg.sv
package os_pkg;
   // One channel's synchronized control inputs
   typedef struct packed {
      logic a_n;
      logic b;
      logic clr_n;
   } os_ctl_t;

   localparam os_ctl_t OS_CTL_IDLE = '{a_n: 1'b1, b: 1'b0, clr_n: 1'b1};

   // Pulse length actually used for a requested width
   function automatic logic [31:0] os_eff_width(input logic [31:0] w);
      return (w == 32'd0) ? 32'd1 : w;
   endfunction
endpackage

// File: rtl/os_sync.sv
module os_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("os_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst)         stage_q[s] <= RST_VAL;
         else if (s == 0) stage_q[s] <= din;
         else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/os_qualify.sv
module os_qualify
   import os_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  os_ctl_t cur,
   output logic    fire
);
   os_ctl_t prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= OS_CTL_IDLE;
      else     prev <= cur;
   end

   logic b_up, a_down, clr_up;
   assign b_up   = cur.b     & ~prev.b;
   assign a_down = ~cur.a_n  &  prev.a_n;
   assign clr_up = cur.clr_n & ~prev.clr_n;

   // each route needs A low, B high and clear high once its edge has happened
   logic armed;
   assign armed = ~cur.a_n & cur.b & cur.clr_n;
   assign fire  = armed & (b_up | a_down | clr_up);
endmodule

// File: rtl/os_counter.sv
module os_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr_ok,
   input  logic          fire,
   input  logic [CW-1:0] width,
   output logic          q
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] remain;
   logic [CW-1:0] load_val;

   assign load_val = (width == '0) ? ONE : width;

   always_ff @(posedge clk) begin
      if (rst) begin
         q      <= 1'b0;
         remain <= '0;
      end else if (!clr_ok) begin
         q      <= 1'b0;
         remain <= '0;
      end else if (q) begin
         if (remain == ONE) q <= 1'b0;
         remain <= remain - ONE;
      end else if (fire) begin
         q      <= 1'b1;
         remain <= load_val;
      end
   end
endmodule

// File: rtl/os_channel.sv
module os_channel
   import os_pkg::*;
#(
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          a_n,
   input  logic          b,
   input  logic          clr_n,
   input  logic [CW-1:0] width,
   output logic          q
);
   os_ctl_t raw, synced;
   logic    fire;

   assign raw = '{a_n: a_n, b: b, clr_n: clr_n};

   os_sync #(
      .STAGES (SYNC_STAGES),
      .W      ($bits(os_ctl_t)),
      .RST_VAL(OS_CTL_IDLE)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw),
      .dout(synced)
   );

   os_qualify u_qual (
      .clk (clk),
      .rst (rst),
      .cur (synced),
      .fire(fire)
   );

   os_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr_ok(synced.clr_n),
      .fire  (fire),
      .width (width),
      .q     (q)
   );
endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
   parameter int NCH         = 2,
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NCH-1:0]    trig_a_n,
   input  logic [NCH-1:0]    trig_b,
   input  logic [NCH-1:0]    clr_n,
   input  logic [NCH*CW-1:0] width,
   output logic [NCH-1:0]    q,
   output logic [NCH-1:0]    q_n
);
   if (NCH < 1) begin : g_bad_nch
      $error("dual_oneshot: NCH must be at least 1");
   end
   if (CW < 1 || CW > 31) begin : g_bad_cw
      $error("dual_oneshot: CW must lie in 1..31");
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      os_channel #(
         .CW         (CW),
         .SYNC_STAGES(SYNC_STAGES)
      ) u_ch (
         .clk  (clk),
         .rst  (rst),
         .a_n  (trig_a_n[i]),
         .b    (trig_b[i]),
         .clr_n(clr_n[i]),
         .width(width[CW*i +: CW]),
         .q    (q[i])
      );
   end

   assign q_n = ~q;
endmodule

// File: rtl/os_checker.sv
module os_checker #(
   parameter int NCH = 2,
   parameter int CW  = 16
) (
   input logic              clk,
   input logic              rst,
   input logic [NCH-1:0]    trig_a_n,
   input logic [NCH-1:0]    trig_b,
   input logic [NCH-1:0]    clr_n,
   input logic [NCH*CW-1:0] width,
   input logic [NCH-1:0]    q,
   input logic [NCH-1:0]    q_n
);
   AST_RESET_LOW: assert property (@(posedge clk) rst |=> (q == '0 && q_n == '1)); // R8

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      logic [CW:0] run_len;
      logic [CW:0] lim_q;
      logic [CW:0] lim_now;
      logic [CW:0] eff_w;

      assign eff_w   = (width[CW*i +: CW] == '0) ? (CW+1)'(1) : {1'b0, width[CW*i +: CW]};
      assign lim_now = (run_len == '0) ? eff_w : lim_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            run_len <= '0;
            lim_q   <= '0;
         end else begin
            run_len <= q[i] ? run_len + 1'b1 : '0;
            if (q[i] && run_len == '0) lim_q <= eff_w;
         end
      end

      AST_CLEAR_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
         (!$past(clr_n[i], 1) && !$past(clr_n[i], 2) && !$past(clr_n[i], 3)) |-> !q[i]); // R4

      AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
         $rose(q[i]) |-> ($past(clr_n[i], 3) && !$past(trig_a_n[i], 3) && $past(trig_b[i], 3))); // R5

      AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (rst)
         q[i] |-> (run_len < lim_now)); // R6
   end
endmodule

bind dual_oneshot os_checker #(.NCH(NCH), .CW(CW)) u_os_chk (
   .clk     (clk),
   .rst     (rst),
   .trig_a_n(trig_a_n),
   .trig_b  (trig_b),
   .clr_n   (clr_n),
   .width   (width),
   .q       (q),
   .q_n     (q_n)
);

// File: tb/sim_dual_oneshot.sv
`timescale 1ns/1ps
module sim_dual_oneshot;
   localparam int NCH = 2;
   localparam int CW  = 16;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NCH-1:0]    trig_a_n = '1;
   logic [NCH-1:0]    trig_b   = '0;
   logic [NCH-1:0]    clr_n    = '1;
   logic [NCH*CW-1:0] width    = '0;
   logic [NCH-1:0]    q, q_n;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   dual_oneshot #(.NCH(NCH), .CW(CW)) u0 (
      .clk(clk), .rst(rst), .trig_a_n(trig_a_n), .trig_b(trig_b),
      .clr_n(clr_n), .width(width), .q(q), .q_n(q_n)
   );

   // behavioural reference: shift queues of samples and a remaining-cycle count
   bit s1a[NCH], s1b[NCH], s1c[NCH];
   bit s2a[NCH], s2b[NCH], s2c[NCH];
   bit pa[NCH],  pb[NCH],  pc[NCH];
   bit mq[NCH];
   int left[NCH];

   always @(posedge clk) begin
      for (int i = 0; i < NCH; i++) begin
         if (rst) begin
            s1a[i] = 1; s1b[i] = 0; s1c[i] = 1;
            s2a[i] = 1; s2b[i] = 0; s2c[i] = 1;
            pa[i]  = 1; pb[i]  = 0; pc[i]  = 1;
            mq[i] = 0; left[i] = 0;
         end else begin
            bit ev;
            int w;
            ev = (!s2a[i] && s2b[i] && s2c[i]) &&
                 ((s2b[i] && !pb[i]) || (!s2a[i] && pa[i]) || (s2c[i] && !pc[i]));
            w = int'(width[CW*i +: CW]);
            if (!s2c[i]) begin
               mq[i] = 0;
            end else if (mq[i]) begin
               left[i] = left[i] - 1;
               if (left[i] == 0) mq[i] = 0;
            end else if (ev) begin
               mq[i] = 1;
               left[i] = (w == 0) ? 1 : w;
            end
            pa[i] = s2a[i]; pb[i] = s2b[i]; pc[i] = s2c[i];
            s2a[i] = s1a[i]; s2b[i] = s1b[i]; s2c[i] = s1c[i];
            s1a[i] = trig_a_n[i]; s1b[i] = trig_b[i]; s1c[i] = clr_n[i];
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model (R10 timing, R8 complement)
   always @(negedge clk) begin
      if (!rst && !done) begin
         for (int i = 0; i < NCH; i++) begin
            chk(q[i] == mq[i], $sformatf("R10 model ch%0d q", i), int'(q[i]), int'(mq[i]));
            chk(q_n[i] == !mq[i], $sformatf("R8 model ch%0d q_n", i), int'(q_n[i]), int'(!mq[i]));
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_len(input int ch, output int lat, output int len);
      lat = 0; len = 0;
      while (!q[ch] && lat < 8) begin @(negedge clk); lat++; end
      while (q[ch] && len < 100000) begin len++; @(negedge clk); end
   endtask

   task automatic stay_low(input int ch, input int n, input string tag);
      int hi = 0;
      repeat (n) begin @(negedge clk); if (q[ch]) hi++; end
      chk(hi == 0, tag, hi, 0);
   endtask

   task automatic to_idle(input int ch);
      @(negedge clk); trig_a_n[ch] = 1'b1;
      @(negedge clk); trig_b[ch] = 1'b0;
      @(negedge clk); clr_n[ch] = 1'b1;
      idle(4);
   endtask

   initial begin
      int lat, len, lat1, len1;
      width[0 +: CW]  = 16'd5;
      width[CW +: CW] = 16'd4;
      repeat (3) @(negedge clk);
      chk(q == '0, "R8 reset q", int'(q), 0);
      chk(q_n == '1, "R8 reset q_n", int'(q_n), 3);
      rst = 1'b0;
      idle(4);

      // R5: A falls while B low -> nothing
      trig_a_n[0] = 1'b0;
      stay_low(0, 6, "R5 A falling with B low");
      // R1: B rises with A low
      @(negedge clk); trig_b[0] = 1'b1;
      pulse_len(0, lat, len);
      chk(lat == 3, "R10 trigger to q latency", lat, 3);
      chk(len == 5, "R1 B-rise pulse length", len, 5);
      to_idle(0);

      // R5: B rises while A high -> nothing
      trig_b[0] = 1'b1;
      stay_low(0, 6, "R5 B rising with A high");
      // R2: A falls with B high
      @(negedge clk); trig_a_n[0] = 1'b0;
      pulse_len(0, lat, len);
      chk(len == 5, "R2 A-fall pulse length", len, 5);
      to_idle(0);

      // R3: clear released with A low and B high
      clr_n[0] = 1'b0;
      @(negedge clk); trig_a_n[0] = 1'b0;
      @(negedge clk); trig_b[0] = 1'b1;
      stay_low(0, 5, "R4 no pulse while clear low");
      @(negedge clk); clr_n[0] = 1'b1;
      pulse_len(0, lat, len);
      chk(len == 5, "R3 clear-rise pulse length", len, 5);
      to_idle(0);

      // R4: truncation by clear with triggers toggling
      width[0 +: CW] = 16'd10;
      trig_a_n[0] = 1'b0;
      @(negedge clk); trig_b[0] = 1'b1;
      while (!q[0]) @(negedge clk);
      idle(2);
      clr_n[0] = 1'b0;
      idle(3);
      chk(q[0] == 1'b0, "R4 truncated q", int'(q[0]), 0);
      chk(q_n[0] == 1'b1, "R4 truncated q_n", int'(q_n[0]), 1);
      trig_b[0] = 1'b0;
      @(negedge clk); trig_b[0] = 1'b1;
      stay_low(0, 6, "R4 triggers ignored under clear");
      @(negedge clk); trig_a_n[0] = 1'b1;
      to_idle(0);

      // R6: zero width yields one cycle
      width[0 +: CW] = 16'd0;
      trig_a_n[0] = 1'b0;
      @(negedge clk); trig_b[0] = 1'b1;
      pulse_len(0, lat, len);
      chk(len == 1, "R6 zero width", len, 1);
      to_idle(0);

      // R7: retrigger attempt during a pulse
      width[0 +: CW] = 16'd8;
      trig_a_n[0] = 1'b0;
      @(negedge clk); trig_b[0] = 1'b1;
      fork
         pulse_len(0, lat, len);
         begin idle(5); trig_b[0] = 1'b0; @(negedge clk); trig_b[0] = 1'b1; end
      join
      chk(len == 8, "R7 length unchanged by retrigger", len, 8);
      stay_low(0, 8, "R7 no second pulse");
      to_idle(0);

      // R9: channel 1 fires while channel 0 is held in clear
      clr_n[0] = 1'b0;
      trig_b[1] = 1'b1;
      @(negedge clk); trig_a_n[1] = 1'b0;
      fork
         pulse_len(1, lat1, len1);
         stay_low(0, 10, "R9 ch0 unaffected by ch1");
      join
      chk(len1 == 4, "R9 ch1 pulse length", len1, 4);
      to_idle(1);
      to_idle(0);

      // R9: both channels at once with different widths
      width[0 +: CW] = 16'd6;
      trig_a_n = '0;
      @(negedge clk); trig_b = '1;
      fork
         pulse_len(0, lat, len);
         pulse_len(1, lat1, len1);
      join
      chk(len == 6, "R9 ch0 simultaneous", len, 6);
      chk(len1 == 4, "R9 ch1 simultaneous", len1, 4);
      to_idle(0);
      to_idle(1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule